// File: doc/BRIEF.md
# Parallel 16-Point Radix-4 FFT

This block computes the forward discrete Fourier transform of a 16-sample complex vector. All sixteen samples arrive together on two wide input buses, one for real parts and one for imaginary parts. Each sample part is a signed 8-bit integer. A pulse on `start` captures the vector. Four cycles later, all sixteen frequency bins appear together on two wide output buses, and `done` marks them valid for one cycle.

Inside, the transform uses two rows of four radix-4 decimation-in-time butterflies. A bank of constant twiddle multipliers sits between the two rows, and registers separate the rows. A new vector may be started on every cycle. Samples and bins are both in natural index order; the stride grouping needed by the first row is done by fixed wiring. Butterfly products by ±j are formed by swapping and negating parts, so they need no multiplier. Twiddle products are truncated back to 8 fractional bits. Each output part is a 20-bit two's complement value with 12 integer bits and 8 fractional bits.

The block does not saturate its outputs. A bin part outside the 12.8 range wraps around. This cannot happen while the sum over all samples of |real| + |imag| stays at or below 2047.

Top module: `quad_fft16`

## Requirements
- R1: While `arst_n` is low, and after its release until the first transform completes, `done` is 0 and every bit of `bin_re` and `bin_im` is 0.
- R2: If `start` is sampled high at rising edge E, `done` is high after edge E+3 and carries that vector's bins. `done` is low in every cycle that no sampled start accounts for.
- R3: Starts on consecutive cycles give `done` pulses on consecutive cycles, and each pulse carries the bins of its own vector.
- R4: An impulse of amplitude a at sample 0 gives exactly real = a·256 and imag = 0 in every bin (raw 12.8 code).
- R5: A constant input c in every sample's real part gives exactly 16·c·256 in bin 0 and exactly 0 in every other bin part.
- R6: For any input within the no-wrap range, each bin k agrees within 2.0 with Σn x[n]·e^(−j2πkn/16). Here bin real = code/256.
- R7: Sample n occupies bits [8n+7:8n] of `smp_re`/`smp_im` as signed two's complement. Bin k occupies bits [20k+19:20k] of `bin_re`/`bin_im` as signed 12.8.
- R8: When no transform completes, `bin_re` and `bin_im` hold their value. Changes on the sample buses while `start` is low have no effect on the outputs.
- R9: A tone A·j^n (bin 4) or A·(−j)^n (bin 12) gives exactly 16·A·256 in that bin's real part and exactly 0 everywhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Capture the sample buses and launch a transform |
| smp_re | input | 128 | Real parts of samples 0..15, 8 bits each |
| smp_im | input | 128 | Imaginary parts of samples 0..15, 8 bits each |
| bin_re | output | 320 | Real parts of bins 0..15, signed 12.8 each |
| bin_im | output | 320 | Imaginary parts of bins 0..15, signed 12.8 each |
| done | output | 1 | One-cycle marker: the bin buses hold a new result |

## Verification
Every result of this block is due after the fourth rising edge, counting the edge that samples `start`. The bench drives on falling edges and reads `done` and the bins on the falling edge that follows that fourth rising edge. For the first vector it also confirms that `done` is still low one falling edge earlier and low again one falling edge later. Back-to-back vectors are read on two adjacent falling edges. The hold check watches six further falling edges with `start` low. The reset checks wait out the internal two-cycle reset release before they sample.

// File: rtl/qfft_pkg.sv
package qfft_pkg;
  localparam int NPT    = 16;
  localparam int RADIX  = 4;
  localparam int SMP_W  = 8;
  localparam int BIN_W  = 20;
  localparam int FRAC_W = 8;
  localparam int COEF_W = FRAC_W + 2;

  // cos(q*pi/8) for q = 0..4, scaled by 2^FRAC_W and rounded
  function automatic int quarter_cos(input int q);
    int raw;
    case (q)
      0: raw = 65536;
      1: raw = 60547;
      2: raw = 46341;
      3: raw = 25080;
      default: raw = 0;
    endcase
    return (raw + (1 << (15 - FRAC_W))) >>> (16 - FRAC_W);
  endfunction

  // cos(2*pi*p/16) in FRAC_W fractional bits
  function automatic int cos_q(input int p);
    int r;
    r = p % 16;
    if (r <= 4)       return quarter_cos(r);
    else if (r <= 8)  return -quarter_cos(8 - r);
    else if (r <= 12) return -quarter_cos(r - 8);
    else              return quarter_cos(16 - r);
  endfunction

  // W16^p = cos - j*sin
  function automatic int tw_re(input int p);
    return cos_q(p);
  endfunction

  function automatic int tw_im(input int p);
    return -cos_q(p + 12);
  endfunction
endpackage

// File: rtl/qfft_rst_sync.sv
module qfft_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/qfft_bfly4.sv
module qfft_bfly4 #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] p_re [4],
  input  logic signed [W-1:0] p_im [4],
  output logic signed [W+1:0] q_re [4],
  output logic signed [W+1:0] q_im [4]
);
  logic signed [W+1:0] er [4];
  logic signed [W+1:0] ei [4];
  logic signed [W+3:0] s_re, s_im, t_re, t_im;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      er[i] = (W+2)'(p_re[i]);
      ei[i] = (W+2)'(p_im[i]);
    end
    q_re[0] = er[0] + er[1] + er[2] + er[3];
    q_im[0] = ei[0] + ei[1] + ei[2] + ei[3];
    // -j*b and +j*d done by part swap and negation
    q_re[1] = er[0] + ei[1] - er[2] - ei[3];
    q_im[1] = ei[0] - er[1] - ei[2] + er[3];
    q_re[2] = er[0] - er[1] + er[2] - er[3];
    q_im[2] = ei[0] - ei[1] + ei[2] - ei[3];
    q_re[3] = er[0] - ei[1] - er[2] + ei[3];
    q_im[3] = ei[0] + er[1] - ei[2] - er[3];

    s_re = (W+4)'(q_re[0]) + (W+4)'(q_re[1]) + (W+4)'(q_re[2]) + (W+4)'(q_re[3]);
    s_im = (W+4)'(q_im[0]) + (W+4)'(q_im[1]) + (W+4)'(q_im[2]) + (W+4)'(q_im[3]);
    t_re = (W+4)'(q_re[0]) - (W+4)'(q_re[1]) + (W+4)'(q_re[2]) - (W+4)'(q_re[3]);
    t_im = (W+4)'(q_im[0]) - (W+4)'(q_im[1]) + (W+4)'(q_im[2]) - (W+4)'(q_im[3]);
    // R6
    bfly_sum_chk: assert ((s_re == ((W+4)'(p_re[0]) <<< 2)) && (s_im == ((W+4)'(p_im[0]) <<< 2)));
    // R6
    bfly_alt_chk: assert ((t_re == ((W+4)'(p_re[2]) <<< 2)) && (t_im == ((W+4)'(p_im[2]) <<< 2)));
  end
endmodule

// File: rtl/qfft_twiddle.sv
module qfft_twiddle
  import qfft_pkg::*;
#(
  parameter int W_IN  = 18,
  parameter int W_OUT = 20,
  parameter int P     = 0
) (
  input  logic signed [W_IN-1:0]  in_re,
  input  logic signed [W_IN-1:0]  in_im,
  output logic signed [W_OUT-1:0] out_re,
  output logic signed [W_OUT-1:0] out_im
);
  localparam int MW  = W_IN + COEF_W + 1;
  localparam int CRE = tw_re(P);
  localparam int CIM = tw_im(P);

  generate
    if (P == 0) begin : g_unity
      assign out_re = W_OUT'(in_re);
      assign out_im = W_OUT'(in_im);
    end else begin : g_rotate
      logic signed [MW-1:0] pr, pi;
      always_comb begin
        pr = MW'(in_re) * MW'(CRE) - MW'(in_im) * MW'(CIM);
        pi = MW'(in_re) * MW'(CIM) + MW'(in_im) * MW'(CRE);
        out_re = W_OUT'(pr >>> FRAC_W);
        out_im = W_OUT'(pi >>> FRAC_W);
      end
    end
  endgenerate
endmodule

// File: rtl/quad_fft16.sv
module quad_fft16
  import qfft_pkg::*;
(
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   start,
  input  logic [NPT*SMP_W-1:0]   smp_re,
  input  logic [NPT*SMP_W-1:0]   smp_im,
  output logic [NPT*BIN_W-1:0]   bin_re,
  output logic [NPT*BIN_W-1:0]   bin_im,
  output logic                   done
);
  localparam int S0_W = SMP_W + FRAC_W;
  localparam int S1_W = S0_W + 2;
  localparam int S2_W = S1_W + 2;
  localparam int S3_W = S2_W + 2;

  logic rst_n;
  logic v0, v1, v2, v3, v0_d, v1_d, v2_d, v3_d;
  logic signed [S0_W-1:0]  s0_re [NPT], s0_im [NPT], s0_re_d [NPT], s0_im_d [NPT];
  logic signed [S1_W-1:0]  y_re  [NPT], y_im  [NPT];
  logic signed [S1_W-1:0]  s1_re [NPT], s1_im [NPT], s1_re_d [NPT], s1_im_d [NPT];
  logic signed [S2_W-1:0]  t_re  [NPT], t_im  [NPT];
  logic signed [S2_W-1:0]  s2_re [NPT], s2_im [NPT], s2_re_d [NPT], s2_im_d [NPT];
  logic signed [S3_W-1:0]  z_re  [NPT], z_im  [NPT];
  logic signed [BIN_W-1:0] s3_re [NPT], s3_im [NPT], s3_re_d [NPT], s3_im_d [NPT];

  qfft_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  // next state: each stage loads only when the stage before holds a valid vector
  always_comb begin
    v0_d = start;
    v1_d = v0;
    v2_d = v1;
    v3_d = v2;
    for (int i = 0; i < NPT; i++) begin
      s0_re_d[i] = start ? $signed({smp_re[i*SMP_W +: SMP_W], {FRAC_W{1'b0}}}) : s0_re[i];
      s0_im_d[i] = start ? $signed({smp_im[i*SMP_W +: SMP_W], {FRAC_W{1'b0}}}) : s0_im[i];
      s1_re_d[i] = v0 ? y_re[i] : s1_re[i];
      s1_im_d[i] = v0 ? y_im[i] : s1_im[i];
      s2_re_d[i] = v1 ? t_re[i] : s2_re[i];
      s2_im_d[i] = v1 ? t_im[i] : s2_im[i];
      s3_re_d[i] = v2 ? BIN_W'(z_re[i]) : s3_re[i];
      s3_im_d[i] = v2 ? BIN_W'(z_im[i]) : s3_im[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0 <= 1'b0;
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      for (int i = 0; i < NPT; i++) begin
        s0_re[i] <= '0;
        s0_im[i] <= '0;
        s1_re[i] <= '0;
        s1_im[i] <= '0;
        s2_re[i] <= '0;
        s2_im[i] <= '0;
        s3_re[i] <= '0;
        s3_im[i] <= '0;
      end
    end else begin
      v0 <= v0_d;
      v1 <= v1_d;
      v2 <= v2_d;
      v3 <= v3_d;
      s0_re <= s0_re_d;
      s0_im <= s0_im_d;
      s1_re <= s1_re_d;
      s1_im <= s1_im_d;
      s2_re <= s2_re_d;
      s2_im <= s2_im_d;
      s3_re <= s3_re_d;
      s3_im <= s3_im_d;
    end
  end

  // first row: butterfly g takes samples g, g+4, g+8, g+12; output k1 goes to slot 4g+k1
  for (genvar g = 0; g < RADIX; g++) begin : g_row1
    logic signed [S0_W-1:0] a_re [RADIX], a_im [RADIX];
    logic signed [S1_W-1:0] o_re [RADIX], o_im [RADIX];
    for (genvar m = 0; m < RADIX; m++) begin : g_wire
      assign a_re[m] = s0_re[RADIX*m + g];
      assign a_im[m] = s0_im[RADIX*m + g];
      assign y_re[RADIX*g + m] = o_re[m];
      assign y_im[RADIX*g + m] = o_im[m];
    end
    qfft_bfly4 #(.W(S0_W)) u_bf (.p_re(a_re), .p_im(a_im), .q_re(o_re), .q_im(o_im));
  end

  // twiddle bank: slot 4g+k1 is rotated by W16^(g*k1)
  for (genvar g = 0; g < RADIX; g++) begin : g_twr
    for (genvar k = 0; k < RADIX; k++) begin : g_twc
      qfft_twiddle #(.W_IN(S1_W), .W_OUT(S2_W), .P(g*k)) u_tw (
        .in_re (s1_re[RADIX*g + k]), .in_im (s1_im[RADIX*g + k]),
        .out_re(t_re[RADIX*g + k]),  .out_im(t_im[RADIX*g + k])
      );
    end
  end

  // second row: butterfly k1 combines slots k1, 4+k1, 8+k1, 12+k1; output k2 is bin k1+4*k2
  for (genvar k = 0; k < RADIX; k++) begin : g_row2
    logic signed [S2_W-1:0] a_re [RADIX], a_im [RADIX];
    logic signed [S3_W-1:0] o_re [RADIX], o_im [RADIX];
    for (genvar m = 0; m < RADIX; m++) begin : g_wire
      assign a_re[m] = s2_re[RADIX*m + k];
      assign a_im[m] = s2_im[RADIX*m + k];
      assign z_re[k + RADIX*m] = o_re[m];
      assign z_im[k + RADIX*m] = o_im[m];
    end
    qfft_bfly4 #(.W(S2_W)) u_bf (.p_re(a_re), .p_im(a_im), .q_re(o_re), .q_im(o_im));
  end

  for (genvar k = 0; k < NPT; k++) begin : g_out
    assign bin_re[k*BIN_W +: BIN_W] = s3_re[k];
    assign bin_im[k*BIN_W +: BIN_W] = s3_im[k];
  end
  assign done = v3;

  // R2
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 4));
  // R8
  bins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v2 |=> ($stable(bin_re) && $stable(bin_im)));
endmodule

// File: tb/quad_fft16_test.sv
module quad_fft16_test;
  import qfft_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic arst_n, start, done;
  logic [NPT*SMP_W-1:0] smp_re, smp_im;
  logic [NPT*BIN_W-1:0] bin_re, bin_im;
  logic [NPT*BIN_W-1:0] snap_re, snap_im;

  quad_fft16 uut (
    .clk(clk), .arst_n(arst_n), .start(start),
    .smp_re(smp_re), .smp_im(smp_im),
    .bin_re(bin_re), .bin_im(bin_im), .done(done)
  );

  int total = 0;
  int bad = 0;
  bit over = 1'b0;
  int xr [NPT];
  int xi [NPT];
  real er [NPT], ei [NPT], er_a [NPT], ei_a [NPT], er_b [NPT], ei_b [NPT];

  // case entry: {kind[3:0], pos[3:0], amp[7:0]}
  // kind 0 impulse at pos, 1 DC, 2 tone at bin pos, 3 pseudo-random seeded by amp
  localparam int NCASE = 11;
  localparam logic [15:0] CASES [NCASE] = '{
    {4'd0, 4'd0,  8'sd100}, {4'd0, 4'd0, -8'sd128}, {4'd0, 4'd5, 8'sd90},
    {4'd1, 4'd0,  8'sd77},  {4'd1, 4'd0, -8'sd100},
    {4'd2, 4'd4,  8'sd100}, {4'd2, 4'd12, -8'sd90},
    {4'd2, 4'd1,  8'sd100}, {4'd2, 4'd7,  8'sd60},
    {4'd3, 4'd0,  8'd13},   {4'd3, 4'd0,  8'd200}
  };

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_tol(input string req, input string what, input longint act, input real exp);
    real a;
    a = real'(act) / 256.0;
    total++;
    if ((a - exp > 2.0) || (exp - a > 2.0)) begin
      bad++;
      $display("FAIL %s %s: actual=%f expected=%f", req, what, a, exp);
    end
  endtask

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
  endfunction

  function automatic longint get_re(input int k);
    return longint'($signed(bin_re[k*BIN_W +: BIN_W]));
  endfunction

  function automatic longint get_im(input int k);
    return longint'($signed(bin_im[k*BIN_W +: BIN_W]));
  endfunction

  task automatic fill(input logic [15:0] e);
    int kind, pos, amp;
    int unsigned st;
    real th;
    kind = int'(e[15:12]);
    pos  = int'(e[11:8]);
    amp  = int'($signed(e[7:0]));
    st   = int'(e[7:0]) + 1;
    for (int n = 0; n < NPT; n++) begin
      th = 2.0 * 3.14159265358979 * real'(pos * n) / 16.0;
      case (kind)
        0: begin xr[n] = (n == pos) ? amp : 0; xi[n] = 0; end
        1: begin xr[n] = amp; xi[n] = 0; end
        2: begin xr[n] = rnd(real'(amp) * $cos(th)); xi[n] = rnd(real'(amp) * $sin(th)); end
        default: begin
          st = st * 1103515245 + 12345;
          xr[n] = int'((st >> 16) % 121) - 60;
          st = st * 1103515245 + 12345;
          xi[n] = int'((st >> 16) % 121) - 60;
        end
      endcase
    end
  endtask

  task automatic ref_dft();
    real th;
    for (int k = 0; k < NPT; k++) begin
      er[k] = 0.0;
      ei[k] = 0.0;
      for (int n = 0; n < NPT; n++) begin
        th = 2.0 * 3.14159265358979 * real'(k * n) / 16.0;
        er[k] += real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
        ei[k] += real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
      end
    end
  endtask

  task automatic load();
    for (int n = 0; n < NPT; n++) begin
      smp_re[n*SMP_W +: SMP_W] = xr[n][SMP_W-1:0];
      smp_im[n*SMP_W +: SMP_W] = xi[n][SMP_W-1:0];
    end
  endtask

  task automatic verify(input string req, input bit exact);
    for (int k = 0; k < NPT; k++) begin
      if (exact) begin
        check(req, $sformatf("bin%0d re", k), get_re(k), longint'(rnd(er[k] * 256.0)));
        check(req, $sformatf("bin%0d im", k), get_im(k), longint'(rnd(ei[k] * 256.0)));
      end else begin
        check_tol(req, $sformatf("bin%0d re", k), get_re(k), er[k]);
        check_tol(req, $sformatf("bin%0d im", k), get_im(k), ei[k]);
      end
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 60000);
    if (!over) begin
      over = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string req;
    bit exact;
    arst_n = 1'b0;
    start  = 1'b0;
    smp_re = '0;
    smp_im = '0;
    tick(3);
    // R1 during reset
    check("R1", "done in reset", longint'(done), 0);
    check("R1", "bins in reset", longint'(|{bin_re, bin_im}), 0);
    arst_n = 1'b1;
    tick(5);
    check("R1", "done after release", longint'(done), 0);
    check("R1", "bins after release", longint'(|{bin_re, bin_im}), 0);

    // table walk
    for (int c = 0; c < NCASE; c++) begin
      fill(CASES[c]);
      ref_dft();
      case (CASES[c][15:12])
        4'd0: begin req = (CASES[c][11:8] == 4'd0) ? "R4" : "R6 R7"; exact = (CASES[c][11:8] == 4'd0); end
        4'd1: begin req = "R5"; exact = 1'b1; end
        4'd2: begin
          exact = (CASES[c][11:8] == 4'd4) || (CASES[c][11:8] == 4'd12);
          req = exact ? "R9" : "R6 R7";
        end
        default: begin req = "R6 R7"; exact = 1'b0; end
      endcase
      load();
      start = 1'b1;
      tick(1);
      start = 1'b0;
      tick(2);
      if (c == 0) check("R2", "done before latency", longint'(done), 0);
      tick(1);
      check("R2", $sformatf("done at latency case %0d", c), longint'(done), 1);
      verify(req, exact);
      tick(1);
      check("R2", "done single cycle", longint'(done), 0);
    end

    // R3 back-to-back starts
    fill({4'd2, 4'd1, 8'sd70});
    ref_dft();
    er_a = er;
    ei_a = ei;
    load();
    start = 1'b1;
    tick(1);
    fill({4'd3, 4'd0, 8'd77});
    ref_dft();
    er_b = er;
    ei_b = ei;
    load();
    tick(1);
    start = 1'b0;
    tick(2);
    check("R3", "done first of pair", longint'(done), 1);
    er = er_a;
    ei = ei_a;
    verify("R3", 1'b0);
    tick(1);
    check("R3", "done second of pair", longint'(done), 1);
    er = er_b;
    ei = ei_b;
    verify("R3", 1'b0);
    snap_re = bin_re;
    snap_im = bin_im;
    tick(1);
    check("R3", "done after pair", longint'(done), 0);

    // R8 sample changes without start do not reach the outputs
    for (int i = 0; i < 6; i++) begin
      fill({4'd3, 4'd0, 8'(i * 31 + 5)});
      load();
      tick(1);
      check("R8", "done without start", longint'(done), 0);
      check("R8", "bins held", longint'((bin_re != snap_re) || (bin_im != snap_im)), 0);
    end

    over = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule